// File: doc/BRIEF.md
# Packed Lane Shifter with Overflow Detection

This block shifts a packed word treated as independent lanes of 8, 16 or 32 bits. Each lane runs the same operation with the same shift amount. Five operations are available:

- left shift that wraps but reports lost sign information;
- left shift that clamps to the most positive or most negative lane value;
- right shift with zero fill;
- right shift with sign fill;
- right shift with sign fill that rounds to nearest, using the last bit shifted out.

An operation is presented with `valid_i`. Its packed result appears on `result_o` one clock later and is held there until the next valid operation. Any lane overflow from a left shift sets a sticky flag, `ovf_o`. Only reset clears that flag. A caller reads it after a run of operations to learn whether any of them lost precision.

Top module: `lane_shifter`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no operation yet, `result_o` is 0, `valid_o` is 0 and `ovf_o` is 0.
- R2: `valid_o` equals `valid_i` delayed by one clock. `result_o` takes the new result at the clock edge that samples `valid_i` high. When `valid_i` is low, `result_o` holds its value.
- R3: When the effective shift amount is 0, every mode returns the operand unchanged and raises no overflow.
- R4: `size_i` selects the lane width: 0 gives 8-bit lanes (four), 1 gives 16-bit lanes (two), 2 or 3 gives one 32-bit lane. The effective shift amount is the low 3, 4 or 5 bits of `amount_i` respectively. Lane k occupies bits [k*W+W-1 : k*W].
- R5: Mode 0 shifts each lane left by s, fills with zeros, and drops the bits that leave the lane. No lane affects another lane.
- R6: In modes 0 and 1, a lane overflows when its top s+1 bits are not all equal. This is the same as the lane's signed value times 2^s falling outside the signed lane range.
- R7: In mode 1, an overflowing lane becomes 0111…1 if its operand was non-negative and 1000…0 if it was negative. A lane that does not overflow matches mode 0.
- R8: Mode 2 shifts each lane right by s and fills with zeros.
- R9: Mode 3 shifts each lane right by s and fills with copies of the lane's sign bit.
- R10: For s > 0, mode 4 gives floor((v + 2^(s-1)) / 2^s), where v is the signed lane value. This equals an arithmetic shift by s-1, adding 1, then shifting by one more.
- R11: `ovf_o` is set at the edge after a valid operation in which any lane overflows. It then stays set until reset. Modes 2, 3 and 4 never set it.
- R12: Mode codes 5, 6 and 7 return the operand unchanged and raise no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| mode_i | input | 3 | Operation code (0 wrap-left, 1 saturating-left, 2 logical-right, 3 arithmetic-right, 4 rounding-right) |
| size_i | input | 2 | Lane width select (0: 8, 1: 16, 2/3: 32) |
| operand_i | input | 32 | Packed lanes to shift |
| amount_i | input | 5 | Shift amount, masked to the lane width |
| valid_o | output | 1 | Result registered from the previous cycle's operation |
| result_o | output | 32 | Packed shifted lanes |
| ovf_o | output | 1 | Sticky left-shift overflow flag |

## Verification
A fault in a lane datapath, such as a wrong sign fill, a wrong rounding increment or a misplaced discard window, shows on `result_o` at the first edge after the offending operation. It shows only for the lane widths and amounts that reach the faulty bits, so the sweeps cover every amount, including amounts wider than the lane, for every lane width. A corrupted sticky flag is visible on `ovf_o` one edge after the triggering operation and stays visible. For that reason, expected flag state is tracked across operations, and the block is reset whenever the expected flag would otherwise mask a later event.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

  typedef enum logic [2:0] {
    SH_LEFT      = 3'd0,
    SH_LEFT_SAT  = 3'd1,
    SH_RIGHT_LOG = 3'd2,
    SH_RIGHT_ARI = 3'd3,
    SH_RIGHT_RND = 3'd4
  } shift_mode_e;

  localparam int NUM_SIZES = 3;
  localparam int MIN_LANE_W = 8;

  function automatic logic [1:0] size_index(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/lshift_lane.sv
module lshift_lane
  import lane_shift_pkg::*;
#(
  parameter int W = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [AW-1:0] amt_i,
  input  shift_mode_e   mode_i,
  output logic [W-1:0]  y_o,
  output logic          ovf_o
);

  logic signed [W-1:0] a_s;
  logic [AW-1:0]       top_pos;
  logic [W-1:0]        top_bits;
  logic                lost;
  logic                is_zero;
  logic [W-1:0]        shl, lsr, asr, sat_val;
  logic signed [W:0]   rnd_pre;
  logic [W:0]          rnd_sum;

  assign a_s      = a_i;
  assign is_zero  = (amt_i == '0);
  // bits from the lane top down to the new sign position must agree
  assign top_pos  = AW'(W-1) - amt_i;
  assign top_bits = a_s >>> top_pos;
  assign lost     = (top_bits != '0) && (top_bits != '1);

  assign shl      = a_i << amt_i;
  assign lsr      = a_i >> amt_i;
  assign asr      = a_s >>> amt_i;
  assign sat_val  = {a_i[W-1], {(W-1){~a_i[W-1]}}};

  // shift by s-1, add one, drop the final bit
  assign rnd_pre  = $signed({a_i[W-1], a_i}) >>> (amt_i - AW'(1));
  assign rnd_sum  = rnd_pre + (W+1)'(1);

  always_comb begin
    y_o   = a_i;
    ovf_o = 1'b0;
    if (!is_zero) begin
      case (mode_i)
        SH_LEFT: begin
          y_o   = shl;
          ovf_o = lost;
        end
        SH_LEFT_SAT: begin
          y_o   = lost ? sat_val : shl;
          ovf_o = lost;
        end
        SH_RIGHT_LOG: y_o = lsr;
        SH_RIGHT_ARI: y_o = asr;
        SH_RIGHT_RND: y_o = rnd_sum[W:1];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!is_zero && mode_i == SH_RIGHT_LOG) begin
      p_lsr_fill_r8: assert (y_o[W-1] == 1'b0);
    end
    if (!is_zero && mode_i == SH_RIGHT_ARI) begin
      p_asr_sign_r9: assert (y_o[W-1] == a_i[W-1]);
    end
    if (!is_zero && mode_i == SH_RIGHT_RND) begin
      p_rnd_near_r10: assert ((y_o == asr) || (y_o == asr + W'(1)));
    end
    if (ovf_o && mode_i == SH_LEFT_SAT) begin
      p_sat_clamp_r7: assert ((y_o[W-1] == a_i[W-1]) && (y_o[W-2] != a_i[W-1]));
    end
    if (mode_i == SH_RIGHT_LOG || mode_i == SH_RIGHT_ARI || mode_i == SH_RIGHT_RND) begin
      p_right_noflag_r11: assert (!ovf_o);
    end
    if (is_zero) begin
      p_zero_pass_r3: assert ((y_o == a_i) && !ovf_o);
    end
  end

endmodule

// File: rtl/lshift_merge.sv
module lshift_merge #(
  parameter int DATA_W = 32,
  parameter int NS     = 3,
  parameter int NL     = 4
) (
  input  logic [NS-1:0][DATA_W-1:0] res_i,
  input  logic [NS-1:0][NL-1:0]     ovf_i,
  input  logic [1:0]                sel_i,
  output logic [DATA_W-1:0]         y_o,
  output logic                      ovf_o
);

  always_comb begin
    y_o   = res_i[0];
    ovf_o = |ovf_i[0];
    for (int k = 1; k < NS; k++) begin
      if (sel_i == 2'(k)) begin
        y_o   = res_i[k];
        ovf_o = |ovf_i[k];
      end
    end
  end

  always_comb begin
    p_sel_range_r4: assert (int'(sel_i) < NS);
  end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import lane_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AMT_W-1:0]  amount_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);

  localparam int NL = DATA_W / MIN_LANE_W;

  shift_mode_e                     mode;
  logic [1:0]                      size_idx;
  logic [NUM_SIZES-1:0][DATA_W-1:0] res_all;
  logic [NUM_SIZES-1:0][NL-1:0]    ovf_all;
  logic [DATA_W-1:0]               merged;
  logic                            merged_ovf;
  logic                            eff_zero;

  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  logic              ovf_q;

  assign mode     = shift_mode_e'(mode_i);
  assign size_idx = size_index(size_i);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W  = MIN_LANE_W << g;
    localparam int N  = DATA_W / W;
    localparam int AW = $clog2(W);
    for (genvar l = 0; l < N; l++) begin : g_lane
      lshift_lane #(.W(W)) u_lane (
        .a_i   (operand_i[l*W +: W]),
        .amt_i (amount_i[AW-1:0]),
        .mode_i(mode),
        .y_o   (res_all[g][l*W +: W]),
        .ovf_o (ovf_all[g][l])
      );
    end
    for (genvar l = N; l < NL; l++) begin : g_pad
      assign ovf_all[g][l] = 1'b0;
    end
  end

  lshift_merge #(.DATA_W(DATA_W), .NS(NUM_SIZES), .NL(NL)) u_merge (
    .res_i(res_all),
    .ovf_i(ovf_all),
    .sel_i(size_idx),
    .y_o  (merged),
    .ovf_o(merged_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= merged;
      if (valid_i && merged_ovf) ovf_q <= 1'b1;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;

  // amount as seen by the selected lane width
  always_comb begin
    case (size_idx)
      2'd0:    eff_zero = (amount_i[$clog2(MIN_LANE_W)-1:0] == '0);
      2'd1:    eff_zero = (amount_i[$clog2(MIN_LANE_W*2)-1:0] == '0);
      default: eff_zero = (amount_i == '0);
    endcase
  end

  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_zero_amt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_zero && !ovf_o) |=> (result_o == $past(operand_i)) && !ovf_o);
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(valid_i));
  p_no_flag_right_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ovf_o && (mode_i inside {3'd2, 3'd3, 3'd4})) |=> !ovf_o);

endmodule

// File: tb/tb_lane_shifter.sv
module tb_lane_shifter;

  localparam int WATCHDOG_NS = 760_000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] operand_i = '0;
  logic [4:0]  amount_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        ovf_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit exp_st   = 1'b0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  lane_shifter dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .size_i(size_i), .operand_i(operand_i), .amount_i(amount_i),
    .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o)
  );

  function automatic void lane_model(input int w, input longint ua, input int s,
                                     input int mode, output longint y, output bit f);
    longint full = 64'sd1 <<< w;
    longint mask = full - 1;
    longint mx   = (64'sd1 <<< (w - 1)) - 1;
    longint mn   = -(64'sd1 <<< (w - 1));
    longint v    = (ua > mx) ? ua - full : ua;
    longint p;
    y = ua;
    f = 1'b0;
    if (s != 0 && mode <= 4) begin
      case (mode)
        0, 1: begin
          p = v * (64'sd1 <<< s);
          f = (p > mx) || (p < mn);
          if (mode == 1 && f) y = (v < 0) ? (mn & mask) : mx;
          else                y = p & mask;
        end
        2: y = ua / (64'sd1 <<< s);
        3: y = (v >>> s) & mask;
        default: y = ((v + (64'sd1 <<< (s - 1))) >>> s) & mask;
      endcase
    end
  endfunction

  function automatic string tag_of(input int mode, input int s, input int amt,
                                   input int w, input bit f);
    if (s == 0)  return "R3";
    if (amt >= w) return "R4";
    case (mode)
      0: return f ? "R6" : "R5";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk);
    rst_ni  = 1'b1;
    exp_st  = 1'b0;
  endtask

  task automatic run_vec(input int size_code, input logic [31:0] op,
                         input int amt, input int mode, input bit keep);
    int idx, w, n, s;
    longint exp_y, ly;
    bit lf, any_f;
    string tag;
    if (exp_st && !keep) do_reset();
    idx = (size_code == 3) ? 2 : size_code;
    w = 8 << idx;
    n = 32 / w;
    s = amt & (w - 1);
    exp_y = 0;
    any_f = 1'b0;
    for (int l = 0; l < n; l++) begin
      lane_model(w, longint'((longint'(op) >> (l * w)) & ((64'sd1 <<< w) - 1)),
                 s, mode, ly, lf);
      exp_y = exp_y | (ly << (l * w));
      any_f = any_f | lf;
    end
    tag = tag_of(mode, s, amt, w, any_f);
    if (keep && exp_st) tag = "R11";
    @(negedge clk);
    valid_i   = 1'b1;
    mode_i    = 3'(mode);
    size_i    = 2'(size_code);
    operand_i = op;
    amount_i  = 5'(amt);
    @(posedge clk);
    #1;
    exp_st = exp_st | any_f;
    n_checks++;
    if (result_o !== exp_y[31:0] || ovf_o !== exp_st || valid_o !== 1'b1) begin
      n_fails++;
      $display("FAIL %s size=%0d mode=%0d amt=%0d op=%h: actual res=%h ovf=%b vld=%b expected res=%h ovf=%b vld=1",
               tag, size_code, mode, amt, op, result_o, ovf_o, valid_o, exp_y[31:0], exp_st);
    end
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      n_fails++;
      $display("FAIL R2 watchdog: actual unfinished expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    n_checks++;
    if (result_o !== 32'h0 || valid_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset: actual res=%h vld=%b ovf=%b expected 0 0 0", result_o, valid_o, ovf_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    n_checks++;
    if (result_o !== 32'h0 || valid_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 post-release: actual res=%h vld=%b ovf=%b expected 0 0 0", result_o, valid_o, ovf_o);
    end

    // 8-bit lanes: every value, amounts past the lane width, every mode code
    for (int a = 0; a < 256; a++) begin
      for (int amt = 0; amt < 16; amt++) begin
        for (int m = 0; m < 8; m++) begin
          logic [7:0] b = 8'(a);
          run_vec(0, {~b, b + 8'd37, b ^ 8'h5A, b}, amt, m, 1'b0);
        end
      end
    end

    // 16-bit lanes
    for (int i = 0; i < 64; i++) begin
      logic [15:0] v;
      v = 16'(i * 1031) ^ 16'(i << 9);
      if (i == 0) v = 16'h8000;
      if (i == 1) v = 16'h7FFF;
      if (i == 2) v = 16'hFFFF;
      for (int amt = 0; amt < 32; amt++) begin
        for (int m = 0; m < 8; m++) begin
          run_vec(1, {~{v[7:0], v[15:8]}, v}, amt, m, 1'b0);
        end
      end
    end

    // 32-bit lane, size codes 2 and 3
    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      v = 32'(i) * 32'h9E3779B9;
      if (i == 0) v = 32'h8000_0000;
      if (i == 1) v = 32'h7FFF_FFFF;
      if (i == 2) v = 32'hFFFF_FFFF;
      if (i == 3) v = 32'h4000_0000;
      for (int amt = 0; amt < 32; amt++) begin
        for (int m = 0; m < 8; m++) begin
          run_vec(2 + (i & 1), v, amt, m, 1'b0);
        end
      end
    end

    // R11: flag raised, then right shifts and clean ops must not clear it
    run_vec(0, 32'h0000_0040, 1, 0, 1'b0);
    run_vec(0, 32'h8080_8080, 3, 3, 1'b1);
    run_vec(1, 32'h0001_0001, 2, 4, 1'b1);
    run_vec(2, 32'h0000_0001, 1, 0, 1'b1);

    // R2: result held and valid_o low while valid_i is low
    held = result_o;
    @(negedge clk);
    valid_i   = 1'b0;
    operand_i = ~operand_i;
    mode_i    = 3'd2;
    @(posedge clk);
    #1;
    n_checks++;
    if (result_o !== held || valid_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R2 hold: actual res=%h vld=%b expected res=%h vld=0", result_o, valid_o, held);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule